// File: doc/BRIEF.md
# Serial Memory Status Register and Write Protection Gate

This block keeps the status register of a serial nonvolatile memory and decides, request by request, whether a write may start. It holds three configuration bits that survive a soft reset: a hardware-guard enable and a two-bit protected-span selector. It also holds a write-arm latch and a busy flag. The protocol engine in front of it forwards decoded commands: arm and disarm pulses, a staged configuration byte for a status write, a data-array write request with its target address, the chip-select level, and a completion pulse from the write timer. The guard pin comes straight from the package.

A data-array write is granted only while the latch is armed and no write is running, and only if the address lies outside the span the selector protects. A status write is staged while chip-select is low and is granted when chip-select is released. The guard pin blocks it only when the guard-enable bit is set. While a write runs, the status byte reads as all ones. Completion disarms the latch. For a status write, completion also loads the new configuration bits.

Top module: `eeprom_status_gate`

## Requirements
- R1: After the hard reset `rst`, the status byte reads 0x00.
- R2: A `latch_set` pulse sets status bit 1 on the next cycle. A `latch_clr` pulse clears it. When both pulses arrive in the same cycle, the clear wins.
- R3: `arr_grant` is high in the request cycle only when the latch is armed, no write is running and the address is not protected. The span selector (status bits 3:2) protects: 00 nothing, 01 the top quarter of the address space (0xC00-0xFFF), 10 the top half (0x800-0xFFF), 11 everything.
- R4: A refused array request leaves the latch armed and starts no write.
- R5: From the cycle after any grant until the cycle after `wr_done`, the status byte reads 0xFF. After completion, bits 1 and 0 read 0.
- R6: A granted status write copies bit 7 and bits 3:2 of the staged byte into the configuration on completion. The staged bits 6:4, 1 and 0 have no effect.
- R7: When the guard enable (status bit 7) is 1 and `guard_n` is low, a status write is refused. When the guard enable is 0, `guard_n` has no effect.
- R8: If `guard_n` falls while a status write is staged and the guard enable is 1, the staged write is dropped. Once a status write has been granted, `guard_n` has no effect on it.
- R9: A `pwr_cycle` pulse clears the latch, the busy flag and any staged write. It keeps bits 7 and 3:2.
- R10: Arm and disarm pulses are ignored while a write runs.
- R11: When no write is running, status bits 6:4 read 0.
- R12: A status write also requires the armed latch. Without it, no grant is given and the configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard reset, clears everything |
| pwr_cycle | input | 1 | Soft reset modelling a power cycle, keeps configuration |
| sel_n | input | 1 | Chip-select level, active low |
| guard_n | input | 1 | Hardware write-guard pin, active low |
| latch_set | input | 1 | Arm pulse |
| latch_clr | input | 1 | Disarm pulse |
| cfg_req | input | 1 | Staged status-write byte valid |
| cfg_data | input | 8 | Staged status-write byte |
| arr_req | input | 1 | Data-array write request |
| arr_addr | input | ADDR_W | Target address of the array write |
| wr_done | input | 1 | Internal write completion pulse |
| status | output | 8 | Formatted status byte |
| arr_grant | output | 1 | Array write granted (same cycle as request) |
| cfg_grant | output | 1 | Status write granted (cycle of chip-select release) |

## Verification
The hardest case to reach is a staged status write that is cancelled by a guard-pin fall while chip-select is still low, because three conditions must hold together: the guard enable must already be set, the latch must be armed, and the release must come after the guard has returned high. The bench first commits a configuration with the guard enable set. It then stages a byte, drops and restores the guard pin between the staging cycle and the release, and checks that no grant appears and the configuration is unchanged. In a second case the guard pin falls inside a running status write, and the bench checks that the new configuration is still loaded on completion.

// File: rtl/esg_pkg.sv
package esg_pkg;

    localparam int STAT_W    = 8;
    localparam int BIT_GUARD = 7;
    localparam int BIT_SPHI  = 3;
    localparam int BIT_SPLO  = 2;
    localparam int BIT_ARM   = 1;
    localparam int BIT_BUSY  = 0;

    typedef enum logic [1:0] {
        JOB_NONE  = 2'd0,
        JOB_ARRAY = 2'd1,
        JOB_CFG   = 2'd2
    } job_e;

    typedef struct packed {
        logic       guard_en;
        logic [1:0] span;
    } nv_t;

    localparam nv_t NV_INIT = '{guard_en: 1'b0, span: 2'b00};

    function automatic nv_t nv_from_byte(input logic [STAT_W-1:0] b);
        nv_t n;
        n.guard_en = b[BIT_GUARD];
        n.span     = {b[BIT_SPHI], b[BIT_SPLO]};
        return n;
    endfunction

    function automatic logic [STAT_W-1:0] fmt_status(input nv_t n, input logic armed,
                                                     input logic busy);
        logic [STAT_W-1:0] s;
        if (busy) begin
            s = '1;
        end else begin
            s            = '0;
            s[BIT_GUARD] = n.guard_en;
            s[BIT_SPHI]  = n.span[1];
            s[BIT_SPLO]  = n.span[0];
            s[BIT_ARM]   = armed;
        end
        return s;
    endfunction

endpackage

// File: rtl/esg_span_check.sv
module esg_span_check #(
    parameter int ADDR_W = 12
) (
    input  logic [1:0]        span,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W:0] QUARTER  = (ADDR_W+1)'(1) << (ADDR_W - 2);
    localparam logic [ADDR_W:0] TOP_QTR  = 3 * QUARTER;
    localparam logic [ADDR_W:0] TOP_HALF = 2 * QUARTER;

    logic [ADDR_W:0] a_ext;
    assign a_ext = {1'b0, addr};

    always_comb begin
        unique case (span)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (a_ext >= TOP_QTR);
            2'b10:   hit = (a_ext >= TOP_HALF);
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/esg_nv_store.sv
module esg_nv_store
    import esg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  nv_t  load_val,
    output nv_t  nv
);
    nv_t nv_q;

    always_ff @(posedge clk) begin
        if (rst)       nv_q <= NV_INIT;
        else if (load) nv_q <= load_val;
    end

    assign nv = nv_q;
endmodule

// File: rtl/esg_cfg_stage.sv
module esg_cfg_stage
    import esg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_cycle,
    input  logic              sel_n,
    input  logic              blocked,
    input  logic              cfg_req,
    input  logic [STAT_W-1:0] cfg_data,
    output logic              release_pend,
    output nv_t               staged
);
    logic sel_q;
    logic pend_q;
    nv_t  staged_q;
    logic rise;

    assign rise = sel_n & ~sel_q;

    always_ff @(posedge clk) begin
        if (rst || pwr_cycle) begin
            sel_q    <= 1'b1;
            pend_q   <= 1'b0;
            staged_q <= NV_INIT;
        end else begin
            sel_q <= sel_n;
            if (rise || blocked) begin
                pend_q <= 1'b0;
            end else if (cfg_req) begin
                pend_q   <= 1'b1;
                staged_q <= nv_from_byte(cfg_data);
            end
        end
    end

    assign release_pend = pend_q & rise;
    assign staged       = staged_q;
endmodule

// File: rtl/esg_seq.sv
module esg_seq
    import esg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_cycle,
    input  logic latch_set,
    input  logic latch_clr,
    input  logic arr_go,
    input  logic cfg_go,
    input  nv_t  cfg_val,
    input  logic wr_done,
    output logic armed,
    output logic busy,
    output logic nv_load,
    output nv_t  nv_val
);
    logic armed_q;
    logic busy_q;
    job_e job_q;
    nv_t  hold_q;

    always_ff @(posedge clk) begin
        if (rst || pwr_cycle) begin
            armed_q <= 1'b0;
            busy_q  <= 1'b0;
            job_q   <= JOB_NONE;
            hold_q  <= NV_INIT;
        end else if (busy_q) begin
            if (wr_done) begin
                busy_q  <= 1'b0;
                armed_q <= 1'b0;
                job_q   <= JOB_NONE;
            end
        end else if (arr_go) begin
            busy_q <= 1'b1;
            job_q  <= JOB_ARRAY;
        end else if (cfg_go) begin
            busy_q <= 1'b1;
            job_q  <= JOB_CFG;
            hold_q <= cfg_val;
        end else if (latch_clr) begin
            armed_q <= 1'b0;
        end else if (latch_set) begin
            armed_q <= 1'b1;
        end
    end

    assign armed   = armed_q;
    assign busy    = busy_q;
    assign nv_load = busy_q & wr_done & (job_q == JOB_CFG) & ~pwr_cycle;
    assign nv_val  = hold_q;
endmodule

// File: rtl/eeprom_status_gate.sv
module eeprom_status_gate
    import esg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_cycle,
    input  logic              sel_n,
    input  logic              guard_n,
    input  logic              latch_set,
    input  logic              latch_clr,
    input  logic              cfg_req,
    input  logic [7:0]        cfg_data,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              wr_done,
    output logic [7:0]        status,
    output logic              arr_grant,
    output logic              cfg_grant
);
    nv_t  nv;
    nv_t  staged;
    nv_t  load_val;
    logic load;
    logic armed;
    logic busy;
    logic hit;
    logic blocked;
    logic release_pend;

    assign blocked = nv.guard_en & ~guard_n;

    esg_span_check #(.ADDR_W(ADDR_W)) u_span (
        .span (nv.span),
        .addr (arr_addr),
        .hit  (hit)
    );

    esg_cfg_stage u_stage (
        .clk          (clk),
        .rst          (rst),
        .pwr_cycle    (pwr_cycle),
        .sel_n        (sel_n),
        .blocked      (blocked),
        .cfg_req      (cfg_req),
        .cfg_data     (cfg_data),
        .release_pend (release_pend),
        .staged       (staged)
    );

    assign arr_grant = arr_req & armed & ~busy & ~hit;
    assign cfg_grant = release_pend & armed & ~busy & ~blocked & ~arr_req;

    esg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .pwr_cycle (pwr_cycle),
        .latch_set (latch_set),
        .latch_clr (latch_clr),
        .arr_go    (arr_grant),
        .cfg_go    (cfg_grant),
        .cfg_val   (staged),
        .wr_done   (wr_done),
        .armed     (armed),
        .busy      (busy),
        .nv_load   (load),
        .nv_val    (load_val)
    );

    esg_nv_store u_nv (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .nv       (nv)
    );

    assign status = fmt_status(nv, armed, busy);
endmodule

// File: rtl/esg_checker.sv
module esg_checker (
    input logic       clk,
    input logic       rst,
    input logic       pwr_cycle,
    input logic       wr_done,
    input logic       arr_grant,
    input logic       cfg_grant,
    input logic [7:0] status
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    p_busy_all_ones_r5: assert property (@(posedge clk) disable iff (rst)
        status[0] |-> status == 8'hFF);

    p_grant_needs_arm_r3: assert property (@(posedge clk) disable iff (rst)
        (arr_grant || cfg_grant) |-> (status[1] && !status[0]));

    p_grant_starts_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (arr_grant || cfg_grant) && !pwr_cycle |=> status[0]);

    p_done_disarms_r5: assert property (@(posedge clk) disable iff (rst)
        status[0] && wr_done && !pwr_cycle |=> (!status[0] && !status[1]));

    p_idle_pad_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !status[0] |-> status[6:4] == 3'b000);

    p_soft_clear_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_cycle |=> status[1:0] == 2'b00);

    p_busy_holds_r10: assert property (@(posedge clk) disable iff (rst)
        status[0] && !wr_done && !pwr_cycle |=> status[0]);

    p_cfg_stable_idle_r6: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(status[0]) && !status[0]
            |-> {status[7], status[3:2]} == $past({status[7], status[3:2]}));
endmodule

bind eeprom_status_gate esg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_cycle (pwr_cycle),
    .wr_done   (wr_done),
    .arr_grant (arr_grant),
    .cfg_grant (cfg_grant),
    .status    (status)
);

// File: tb/eeprom_status_gate_bench.sv
module eeprom_status_gate_bench;
    localparam int ADDR_W = 12;
    localparam int NVEC   = 9;
    // {span[1:0], addr[11:0], expected grant}
    localparam logic [14:0] VEC [0:NVEC-1] = '{
        {2'b00, 12'h000, 1'b1},
        {2'b00, 12'hFFF, 1'b1},
        {2'b01, 12'hBFF, 1'b1},
        {2'b01, 12'hC00, 1'b0},
        {2'b01, 12'hFFF, 1'b0},
        {2'b10, 12'h7FF, 1'b1},
        {2'b10, 12'h800, 1'b0},
        {2'b11, 12'h000, 1'b0},
        {2'b11, 12'h5A5, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_cycle = 1'b0;
    logic sel_n = 1'b1;
    logic guard_n = 1'b1;
    logic latch_set = 1'b0;
    logic latch_clr = 1'b0;
    logic cfg_req = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic arr_req = 1'b0;
    logic [ADDR_W-1:0] arr_addr = '0;
    logic wr_done = 1'b0;
    logic [7:0] status;
    logic arr_grant;
    logic cfg_grant;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    eeprom_status_gate #(.ADDR_W(ADDR_W)) u_eeprom_status_gate (
        .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .sel_n(sel_n),
        .guard_n(guard_n), .latch_set(latch_set), .latch_clr(latch_clr),
        .cfg_req(cfg_req), .cfg_data(cfg_data), .arr_req(arr_req),
        .arr_addr(arr_addr), .wr_done(wr_done), .status(status),
        .arr_grant(arr_grant), .cfg_grant(cfg_grant)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic arm();
        latch_set = 1'b1;
        tick();
        latch_set = 1'b0;
    endtask

    task automatic disarm();
        latch_clr = 1'b1;
        tick();
        latch_clr = 1'b0;
    endtask

    task automatic finish_write();
        wr_done = 1'b1;
        tick();
        wr_done = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] d, input logic exp, input string tag);
        cfg_req  = 1'b1;
        cfg_data = d;
        sel_n    = 1'b0;
        tick();
        cfg_req = 1'b0;
        sel_n   = 1'b1;
        #1;
        chk({7'b0, cfg_grant}, {7'b0, exp}, tag);
        tick();
        if (exp) begin
            chk(status, 8'hFF, "R5 busy during status write");
            finish_write();
        end
    endtask

    task automatic arr_try(input logic [ADDR_W-1:0] a, input logic exp, input string tag);
        arr_req  = 1'b1;
        arr_addr = a;
        #1;
        chk({7'b0, arr_grant}, {7'b0, exp}, tag);
        tick();
        arr_req = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        chk(status, 8'h00, "R1 reset status, R11 pad bits");

        // R2 arm / disarm / both
        arm();
        chk(status, 8'h02, "R2 arm");
        disarm();
        chk(status, 8'h00, "R2 disarm");
        arm();
        latch_set = 1'b1; latch_clr = 1'b1;
        tick();
        latch_set = 1'b0; latch_clr = 1'b0;
        chk(status, 8'h00, "R2 clear wins");

        // R3 unarmed array request
        arr_try(12'h000, 1'b0, "R3 unarmed refused");

        // R3/R4/R5 table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] sp;
            logic [7:0] base;
            sp   = VEC[i][14:13];
            base = {4'b0, sp, 2'b00};
            arm();
            cfg_write(base, 1'b1, "R6 program span");
            chk(status, base, "R6 span loaded");
            arm();
            arr_try(VEC[i][12:1], VEC[i][0], "R3 span/address grant");
            if (VEC[i][0]) begin
                chk(status, 8'hFF, "R5 busy after array grant");
                finish_write();
                chk(status, base, "R5 completion disarms");
            end else begin
                chk(status, base | 8'h02, "R4 refused keeps arm, no busy");
                disarm();
            end
        end

        // R6 staged byte all ones, R11 pad bits
        arm();
        cfg_write(8'hFF, 1'b1, "R6 write all ones");
        chk(status, 8'h8C, "R6 only bits 7,3,2 loaded, R11");

        // R7 guard enabled + guard low blocks
        arm();
        guard_n = 1'b0;
        cfg_write(8'h00, 1'b0, "R7 guard blocks");
        guard_n = 1'b1;
        chk(status, 8'h8E, "R7 config unchanged, still armed");
        cfg_write(8'h00, 1'b1, "R7 guard high allows");
        chk(status, 8'h00, "R7 config cleared");

        // R7 guard disabled: pin ignored
        arm();
        guard_n = 1'b0;
        cfg_write(8'h0C, 1'b1, "R7 guard ignored when disabled");
        guard_n = 1'b1;
        chk(status, 8'h0C, "R7 load with pin low");

        // R8 cancel while staged
        arm();
        cfg_write(8'h8C, 1'b1, "R8 enable guard");
        arm();
        cfg_req = 1'b1; cfg_data = 8'h04; sel_n = 1'b0;
        tick();
        cfg_req = 1'b0; guard_n = 1'b0;
        tick();
        guard_n = 1'b1;
        tick();
        sel_n = 1'b1;
        #1;
        chk({7'b0, cfg_grant}, 8'h00, "R8 staged write dropped");
        tick();
        chk(status, 8'h8E, "R8 config kept after drop");

        // R8 guard fall during running write has no effect
        cfg_req = 1'b1; cfg_data = 8'h04; sel_n = 1'b0;
        tick();
        cfg_req = 1'b0; sel_n = 1'b1;
        #1;
        chk({7'b0, cfg_grant}, 8'h01, "R8 grant before guard fall");
        tick();
        guard_n = 1'b0;
        tick();
        finish_write();
        guard_n = 1'b1;
        chk(status, 8'h04, "R8 running write completes");

        // R10 pulses ignored while busy
        arm();
        arr_try(12'h000, 1'b1, "R10 start write");
        latch_clr = 1'b1;
        tick();
        latch_clr = 1'b0;
        chk(status, 8'hFF, "R10 disarm ignored, still busy");
        latch_set = 1'b1;
        tick();
        latch_set = 1'b0;
        finish_write();
        chk(status, 8'h04, "R10 arm ignored during busy");

        // R9 soft reset
        arm();
        pwr_cycle = 1'b1;
        tick();
        pwr_cycle = 1'b0;
        chk(status, 8'h04, "R9 soft reset keeps config, clears arm");
        arm();
        arr_try(12'h100, 1'b1, "R9 start write");
        pwr_cycle = 1'b1;
        tick();
        pwr_cycle = 1'b0;
        chk(status, 8'h04, "R9 soft reset clears busy");

        // R12 status write without arm
        cfg_write(8'h08, 1'b0, "R12 unarmed status write refused");
        chk(status, 8'h04, "R12 config unchanged");

        // R1 hard reset clears config
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(status, 8'h00, "R1 hard reset clears config");

        ended = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule